// File: doc/BRIEF.md
# Gate Driver Fault Latch

This block guards the six gate outputs of a three-leg half-bridge driver. It takes two digital flags from external comparators. One reports that the main supply has dropped under its undervoltage threshold. The other reports that the sensed bridge current has driven the shunt voltage above the trip reference. Either flag sets a fault latch. While the latch is set, an inhibit forces every high-side and low-side gate output off, and an active-low fault indicator is driven low.

The three high-side and three low-side commands are active low. With the latch clear, each gate output is the inverse of its command. The latch has no release pin. Software or a system controller releases it by parking all three low-side commands at their inactive (high) level for longer than a programmed number of clock cycles. A power-on reset, which stands for a supply recycle, also releases it. Comparator thresholds and hysteresis belong to the external comparators and are outside this block.

Top module: `gate_fault_guard`

## Requirements
- R1: After power-on reset (rst_n low, then high) the latch is clear: fault_n is 1, inhibit is 0.
- R2: While the latch is clear, hi_gate[i] equals the inverse of hi_cmd_n[i] and lo_gate[i] equals the inverse of lo_cmd_n[i] in the same cycle (commands active low, outputs active high).
- R3: uv_flag high at a rising clock edge sets the latch, so fault_n is 0 and inhibit is 1 after that edge.
- R4: oc_trip high at a rising clock edge sets the latch in the same way as uv_flag.
- R5: While the latch is set, all six gate outputs are 0 whatever the commands.
- R6: Once set, the latch stays set after both flags return low, for as long as any low-side command is low (active).
- R7: The latch clears at the (CLEAR_CYCLES+1)-th consecutive rising edge at which it is set and all three lo_cmd_n bits are 1. After CLEAR_CYCLES such edges it is still set.
- R8: A low on any lo_cmd_n bit at an edge during the clear window restarts the count from zero.
- R9: Set has priority over clear. If a flag is high when the window completes, the latch stays set and the count holds at its limit. The latch then clears at the first edge where both flags are low and all low-side commands are still high.
- R10: The high-side commands have no effect on the clear window.
- R11: A power-on reset clears a set latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (supply recycle) |
| uv_flag | input | 1 | Supply undervoltage flag, high = undervoltage |
| oc_trip | input | 1 | Overcurrent trip flag, high = shunt voltage above reference |
| hi_cmd_n | input | 3 | High-side commands per leg, active low |
| lo_cmd_n | input | 3 | Low-side commands per leg, active low |
| hi_gate | output | 3 | High-side gate outputs, high = on |
| lo_gate | output | 3 | Low-side gate outputs, high = on |
| inhibit | output | 1 | High while the fault latch is set |
| fault_n | output | 1 | Fault indicator, low while the latch is set |

## Verification
Directed sequences set the latch from each flag on its own. They then hold the low-side commands all high for exactly CLEAR_CYCLES edges and then for one edge more, which pins down the off-by-one in the window. Further patterns insert one low-side pulse near the end of the window to show that the count restarts rather than merely pauses. They toggle the high-side commands through a window to show that those commands are ignored, and they keep a flag high past the window end to separate set priority from a plain timeout. Random command and flag traffic, biased towards long all-high stretches, is compared every cycle against a bench model of the latch. Power-on reset is applied with the latch set.

// File: rtl/gate_fault_guard.sv
module gate_fault_guard #(
  parameter int unsigned CLEAR_CYCLES = 500,
  parameter int unsigned LEGS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uv_flag,
  input  logic            oc_trip,
  input  logic [LEGS-1:0] hi_cmd_n,
  input  logic [LEGS-1:0] lo_cmd_n,
  output logic [LEGS-1:0] hi_gate,
  output logic [LEGS-1:0] lo_gate,
  output logic            inhibit,
  output logic            fault_n
);

  localparam int unsigned CW = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CLEAR_CYCLES);

  logic          latched;
  logic [CW-1:0] hold_cnt;
  logic          trip;
  logic          lows_idle;
  logic          window_done;

  assign trip        = uv_flag | oc_trip;
  assign lows_idle   = &lo_cmd_n;
  assign window_done = hold_cnt == LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      hold_cnt <= '0;
    end else begin
      if (latched && lows_idle) begin
        if (!window_done)
          hold_cnt <= hold_cnt + 1'b1;
        else if (!trip)
          hold_cnt <= '0;
      end else begin
        hold_cnt <= '0;
      end

      if (trip)
        latched <= 1'b1;
      else if (latched && lows_idle && window_done)
        latched <= 1'b0;
    end
  end

  assign inhibit = latched;
  assign fault_n = ~latched;
  assign hi_gate = inhibit ? '0 : ~hi_cmd_n;
  assign lo_gate = inhibit ? '0 : ~lo_cmd_n;

  // R3 R4
  set_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag || oc_trip) |=> (!fault_n && inhibit));

  // R5
  gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (hi_gate == '0 && lo_gate == '0));

  // R6
  hold_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !(&lo_cmd_n)) |=> !fault_n);

  // R7
  release_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> ($past(&lo_cmd_n) && !$past(uv_flag) && !$past(oc_trip)));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= LIMIT);

  // R9
  set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && (uv_flag || oc_trip)) |=> !fault_n);

endmodule

// File: tb/test_gate_fault_guard.sv
module test_gate_fault_guard;
  localparam int unsigned N = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uv_flag = 1'b0;
  logic       oc_trip = 1'b0;
  logic [2:0] hi_cmd_n = 3'b111;
  logic [2:0] lo_cmd_n = 3'b111;
  logic [2:0] hi_gate, lo_gate;
  logic       inhibit, fault_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  bit m_fault = 1'b0;
  int m_cnt   = 0;

  gate_fault_guard #(.CLEAR_CYCLES(N), .LEGS(3)) i_gate_fault_guard (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .oc_trip(oc_trip),
    .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n), .hi_gate(hi_gate),
    .lo_gate(lo_gate), .inhibit(inhibit), .fault_n(fault_n));

  always #10 clk = ~clk;

  // reference: latch and window count taken from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fault = 1'b0;
      m_cnt = 0;
    end else begin
      if (m_fault && (&lo_cmd_n)) begin
        if (m_cnt < N) m_cnt = m_cnt + 1;
        else if (!(uv_flag || oc_trip)) begin m_fault = 1'b0; m_cnt = 0; end
      end else m_cnt = 0;
      if (uv_flag || oc_trip) m_fault = 1'b1;
    end
  end

  function automatic logic [7:0] exp_out(bit f, logic [2:0] h, logic [2:0] l);
    return f ? {2'b10, 6'b0} : {2'b01, ~h, ~l};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_model(string req);
    chk(req, {inhibit, fault_n, hi_gate, lo_gate}, exp_out(m_fault, hi_cmd_n, lo_cmd_n));
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1", {inhibit, fault_n}, 2'b01);

    // R2
    hi_cmd_n = 3'b010; lo_cmd_n = 3'b101; #1;
    chk("R2", {hi_gate, lo_gate}, {3'b101, 3'b010});
    hi_cmd_n = 3'b111; lo_cmd_n = 3'b110; #1;
    chk("R2", {hi_gate, lo_gate}, {3'b000, 3'b001});

    // R3 then R5, R6
    lo_cmd_n = 3'b011; hi_cmd_n = 3'b000;
    @(negedge clk); uv_flag = 1'b1;
    step(1); uv_flag = 1'b0;
    chk("R3", {inhibit, fault_n}, 2'b10);
    chk("R5", {hi_gate, lo_gate}, 6'b0);
    step(40);
    chk("R6", {fault_n, hi_gate, lo_gate}, 7'b0);

    // R7: exactly N idle edges keep the latch, N+1 clears
    lo_cmd_n = 3'b111; hi_cmd_n = 3'b111;
    step(N);
    chk("R7", fault_n, 1'b0);
    step(1);
    chk("R7", fault_n, 1'b1);

    // R4 then R8 restart
    @(negedge clk); oc_trip = 1'b1;
    step(1); oc_trip = 1'b0;
    chk("R4", {inhibit, fault_n}, 2'b10);
    step(N - 2);
    lo_cmd_n = 3'b101;
    step(1);
    lo_cmd_n = 3'b111;
    step(N);
    chk("R8", fault_n, 1'b0);
    step(1);
    chk("R8", fault_n, 1'b1);

    // R10: high-side toggling during the window
    @(negedge clk); uv_flag = 1'b1;
    step(1); uv_flag = 1'b0;
    for (int k = 0; k < N; k++) begin
      hi_cmd_n = 3'($urandom);
      step(1);
    end
    chk("R10", fault_n, 1'b0);
    step(1);
    chk("R10", fault_n, 1'b1);

    // R9: flag held past window end
    hi_cmd_n = 3'b111;
    @(negedge clk); oc_trip = 1'b1;
    step(N + 6);
    chk("R9", fault_n, 1'b0);
    oc_trip = 1'b0;
    step(1);
    chk("R9", fault_n, 1'b1);

    // R11
    @(negedge clk); uv_flag = 1'b1; lo_cmd_n = 3'b000;
    step(1); uv_flag = 1'b0;
    chk("R11", fault_n, 1'b0);
    rst_n = 1'b0; #2;
    chk("R11", {inhibit, fault_n}, 2'b01);
    step(1); rst_n = 1'b1;
    step(1);
    chk("R11", {inhibit, fault_n}, 2'b01);

    // random traffic against the model: R2 R3 R4 R5 R7 R8 R9
    for (int b = 0; b < 150; b++) begin
      int len = 5 + ($urandom % (2 * N));
      bit idle = ($urandom % 3) != 0;
      for (int k = 0; k < len; k++) begin
        uv_flag  = ($urandom % 40) == 0;
        oc_trip  = ($urandom % 40) == 0;
        hi_cmd_n = 3'($urandom);
        lo_cmd_n = idle ? (($urandom % 30) == 0 ? 3'($urandom) : 3'b111) : 3'($urandom);
        #1;
        chk_model("R2/R5 random");
        step(1);
        chk_model("R7/R9 random");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule